// File: doc/BRIEF.md
# Working-Register Addressed Register File

This block is the byte register file of a small 8-bit controller core. It holds 236 general-purpose byte cells at addresses 04H to EFH, the register pointer at FDH, and an address front end that resolves each access to a physical address. An access can give a full 8-bit address, or a 4-bit working-register number. The 4-bit number is joined to the upper nibble of the register pointer, so the pointer selects one of sixteen groups of sixteen registers.

A direct 8-bit address whose upper nibble is E is also taken as a working-register number. Physical cells E0H to EFH can therefore be reached only through a working-register reference or through an indirect (literal) reference. Each port can move a single byte or a 16-bit pair. In a pair the high byte sits at an even address and the low byte at the next address. A protection window over 80H to EFH can be switched on. While it is on, reads in the window return zero and writes to it are dropped.

There is one combinational read port and one write port that is clocked on the rising edge. The register pointer can be loaded from a dedicated load input or written through the write port. Reset clears only the pointer. The general-purpose cells keep their contents.

Top module: `rf_wreg_file`

## Requirements
- R1: A byte write to a general-purpose address (04H–EFH, resolved) is stored at the rising edge. A byte read is combinational, returns the byte on rd_data[7:0], and shows the new value in the cycle after the write.
- R2: Access mode 01 (working) resolves the address to {pointer[7:4], addr[3:0]}, and rd_phys shows this resolved address.
- R3: Mode 00 (direct) uses the address literally unless its upper nibble is EH, in which case it resolves like mode 01. Modes 10 and 11 (indirect) always use the address literally, including E0H–EFH.
- R4: A 16-bit access (wide=1) at an even resolved address n moves the high byte to or from n and the low byte to or from n+1. Data travels on bits [15:8] and [7:0]. A byte read drives rd_data[15:8] to 00H.
- R5: A 16-bit access whose resolved base is odd, or whose pair is not wholly inside 04H–EFH, is invalid. The port's error flag (rd_err or wr_err) goes high, no cell changes, and the read returns 0000H.
- R6: rp_load loads rp_value into the register pointer at the rising edge. A byte write to resolved address FDH also loads it. If both happen in the same cycle, rp_load wins. A byte read of FDH returns the pointer.
- R7: While prot_en is 1, an access touching 80H–EFH is blocked: the read returns 0000H and the write is dropped. Locations below 80H are unaffected, and clearing prot_en makes the stored data visible again.
- R8: A synchronous active-high reset sets the register pointer to 00H and leaves every general-purpose cell unchanged.
- R9: Resolved addresses outside 04H–EFH other than FDH hold no storage here. Byte reads of them return 00H and byte writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_mode | input | 2 | Read addressing mode: 00 direct, 01 working, 1x indirect |
| rd_wide | input | 1 | Read is a 16-bit pair |
| rd_addr | input | 8 | Read address or working-register number |
| rd_data | output | 16 | Read data; byte reads on [7:0] |
| rd_phys | output | 8 | Resolved read address |
| rd_err | output | 1 | Read pair is invalid |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | Write addressing mode, same encoding as rd_mode |
| wr_wide | input | 1 | Write is a 16-bit pair |
| wr_addr | input | 8 | Write address or working-register number |
| wr_data | input | 16 | Write data; byte writes use [7:0] |
| wr_err | output | 1 | Write pair is invalid (qualified by wr_en) |
| rp_load | input | 1 | Load the register pointer |
| rp_value | input | 8 | Value for rp_load |
| prot_en | input | 1 | Enables the 80H–EFH protection window |

## Verification
The bench aims at the places where address resolution can go wrong. A design that redirects only in working mode would read the literal E5H location through a direct reference. One that also redirects indirect references could never reach E0H–EFH. Pair ordering is checked by reading back each half as a single byte, which exposes swapped bytes. Odd and out-of-range pair writes are followed by reads of the neighbouring cells, which exposes a design that writes before it rejects. The bench also checks the 7FH/80H protection edge, the priority of the pointer load over a port write to FDH, and data retained across reset. These expose a window placed one address off, a wrong priority, or a reset that clears storage.

// File: rtl/rf_wreg_pkg.sv
package rf_wreg_pkg;

    localparam logic [1:0] AM_DIRECT  = 2'b00;
    localparam logic [1:0] AM_WORKING = 2'b01;

    localparam logic [3:0] REDIRECT_NIB = 4'hE;

    typedef enum logic [1:0] {
        TK_GP   = 2'd0,
        TK_RP   = 2'd1,
        TK_VOID = 2'd2,
        TK_BAD  = 2'd3
    } target_e;

    typedef struct packed {
        logic [7:0] phys;
        target_e    kind;
        logic       blocked;
    } access_t;

    function automatic logic [7:0] resolve_addr(input logic [1:0] mode,
                                                input logic [7:0] addr,
                                                input logic [3:0] grp);
        logic [7:0] res;
        if (mode[1])
            res = addr;
        else if (mode == AM_WORKING || addr[7:4] == REDIRECT_NIB)
            res = {grp, addr[3:0]};
        else
            res = addr;
        return res;
    endfunction

endpackage

// File: rtl/rf_addr_xlate.sv
module rf_addr_xlate
    import rf_wreg_pkg::*;
#(
    parameter logic [7:0] GP_FIRST   = 8'h04,
    parameter logic [7:0] GP_LAST    = 8'hEF,
    parameter logic [7:0] PROT_FIRST = 8'h80,
    parameter logic [7:0] RP_LOC     = 8'hFD
) (
    input  logic [1:0] mode,
    input  logic       wide,
    input  logic [7:0] addr,
    input  logic [3:0] grp,
    input  logic       prot_en,
    output access_t    acc
);

    logic [7:0] phys;
    logic [7:0] top_byte;
    target_e    kind;
    logic       blocked;

    always_comb begin
        phys     = resolve_addr(mode, addr, grp);
        top_byte = phys + {7'b0, wide};
        kind     = TK_VOID;
        if (wide) begin
            if (phys[0] || phys < GP_FIRST || phys >= GP_LAST)
                kind = TK_BAD;
            else
                kind = TK_GP;
        end else if (phys >= GP_FIRST && phys <= GP_LAST) begin
            kind = TK_GP;
        end else if (phys == RP_LOC) begin
            kind = TK_RP;
        end
        blocked = prot_en && (kind == TK_GP) && (top_byte >= PROT_FIRST);
        acc = '{phys: phys, kind: kind, blocked: blocked};
    end

endmodule

// File: rtl/rf_gp_store.sv
module rf_gp_store #(
    parameter int         DW       = 8,
    parameter logic [7:0] GP_FIRST = 8'h04,
    parameter logic [7:0] GP_LAST  = 8'hEF
) (
    input  logic            clk,
    input  logic            we,
    input  logic            we_wide,
    input  logic [7:0]      waddr,
    input  logic [2*DW-1:0] wdata,
    input  logic [7:0]      raddr,
    output logic [DW-1:0]   rd_hi,
    output logic [DW-1:0]   rd_lo
);

    localparam int         DEPTH    = int'(GP_LAST) - int'(GP_FIRST) + 1;
    localparam logic [7:0] LAST_IDX = GP_LAST - GP_FIRST;

    // No reset on purpose: contents survive a core reset.
    logic [DW-1:0] cells [DEPTH];

    logic [7:0] widx, widx1, ridx, ridx1;

    always_comb begin
        widx  = waddr - GP_FIRST;
        widx1 = widx + 8'd1;
        ridx  = raddr - GP_FIRST;
        ridx1 = ridx + 8'd1;
        rd_hi = (ridx  <= LAST_IDX) ? cells[ridx]  : '0;
        rd_lo = (ridx1 <= LAST_IDX) ? cells[ridx1] : '0;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            if (we_wide) begin
                cells[widx]  <= wdata[2*DW-1:DW];
                cells[widx1] <= wdata[DW-1:0];
            end else begin
                cells[widx]  <= wdata[DW-1:0];
            end
        end
    end

endmodule

// File: rtl/rf_ptr_reg.sv
module rf_ptr_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_val,
    output logic [DW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (bus_we)
            ptr <= bus_val;
    end

endmodule

// File: rtl/rf_wreg_file.sv
module rf_wreg_file
    import rf_wreg_pkg::*;
#(
    parameter logic [7:0] GP_FIRST   = 8'h04,
    parameter logic [7:0] GP_LAST    = 8'hEF,
    parameter logic [7:0] PROT_FIRST = 8'h80,
    parameter logic [7:0] RP_LOC     = 8'hFD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  rd_mode,
    input  logic        rd_wide,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic [7:0]  rd_phys,
    output logic        rd_err,
    input  logic        wr_en,
    input  logic [1:0]  wr_mode,
    input  logic        wr_wide,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        wr_err,
    input  logic        rp_load,
    input  logic [7:0]  rp_value,
    input  logic        prot_en
);

    localparam int DW = 8;

    logic [DW-1:0] rp_q;
    access_t       racc, wacc;
    logic [DW-1:0] st_hi, st_lo;
    logic          st_we, rp_bus_we;

    rf_addr_xlate #(
        .GP_FIRST(GP_FIRST), .GP_LAST(GP_LAST),
        .PROT_FIRST(PROT_FIRST), .RP_LOC(RP_LOC)
    ) u_rd_xlate (
        .mode(rd_mode), .wide(rd_wide), .addr(rd_addr),
        .grp(rp_q[7:4]), .prot_en(prot_en), .acc(racc)
    );

    rf_addr_xlate #(
        .GP_FIRST(GP_FIRST), .GP_LAST(GP_LAST),
        .PROT_FIRST(PROT_FIRST), .RP_LOC(RP_LOC)
    ) u_wr_xlate (
        .mode(wr_mode), .wide(wr_wide), .addr(wr_addr),
        .grp(rp_q[7:4]), .prot_en(prot_en), .acc(wacc)
    );

    assign st_we     = wr_en && (wacc.kind == TK_GP) && !wacc.blocked;
    assign rp_bus_we = wr_en && (wacc.kind == TK_RP);
    assign wr_err    = wr_en && (wacc.kind == TK_BAD);

    rf_gp_store #(
        .DW(DW), .GP_FIRST(GP_FIRST), .GP_LAST(GP_LAST)
    ) u_store (
        .clk(clk), .we(st_we), .we_wide(wr_wide), .waddr(wacc.phys),
        .wdata(wr_data), .raddr(racc.phys), .rd_hi(st_hi), .rd_lo(st_lo)
    );

    rf_ptr_reg #(.DW(DW)) u_ptr (
        .clk(clk), .rst(rst), .load(rp_load), .load_val(rp_value),
        .bus_we(rp_bus_we), .bus_val(wr_data[DW-1:0]), .ptr(rp_q)
    );

    always_comb begin
        rd_data = '0;
        unique case (racc.kind)
            TK_GP: begin
                if (!racc.blocked)
                    rd_data = rd_wide ? {st_hi, st_lo} : {8'h00, st_hi};
            end
            TK_RP:   rd_data = {8'h00, rp_q};
            default: rd_data = '0;
        endcase
    end

    assign rd_phys = racc.phys;
    assign rd_err  = (racc.kind == TK_BAD);

endmodule

// File: rtl/rf_wreg_file_chk.sv
module rf_wreg_file_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  rd_mode,
    input logic        rd_wide,
    input logic [7:0]  rd_addr,
    input logic [15:0] rd_data,
    input logic [7:0]  rd_phys,
    input logic        rd_err,
    input logic        wr_en,
    input logic [1:0]  wr_mode,
    input logic        wr_wide,
    input logic [7:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        prot_en,
    input logic [7:0]  rp_q
);

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_wide && wr_mode == 2'b10 && wr_addr >= 8'h04 &&
         wr_addr <= 8'hEF && (!prot_en || wr_addr < 8'h80))
        |=> (!(rd_mode == 2'b10 && !rd_wide && rd_addr == $past(wr_addr) &&
               (!prot_en || rd_addr < 8'h80)) ||
             rd_data == {8'h00, $past(wr_data[7:0])}));              // R1

    AST_WORKING_LOW_NIB: assert property (@(posedge clk) disable iff (rst)
        (rd_mode == 2'b01) |-> (rd_phys == {rp_q[7:4], rd_addr[3:0]})); // R2

    AST_LITERAL_PATHS: assert property (@(posedge clk) disable iff (rst)
        (rd_mode[1] || (rd_mode == 2'b00 && rd_addr[7:4] != 4'hE))
        |-> (rd_phys == rd_addr));                                     // R3

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_wide |-> (rd_data[15:8] == 8'h00));                        // R4

    AST_ODD_PAIR_ERR: assert property (@(posedge clk) disable iff (rst)
        (rd_wide && rd_phys[0]) |-> (rd_err && rd_data == 16'h0000));  // R5

    AST_PROT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (prot_en && !rd_wide && rd_phys >= 8'h80 && rd_phys <= 8'hEF)
        |-> (rd_data == 16'h0000));                                    // R7

    AST_PTR_AFTER_RESET: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (rp_q == 8'h00));                     // R8

endmodule

bind rf_wreg_file rf_wreg_file_chk u_chk (
    .clk(clk), .rst(rst), .rd_mode(rd_mode), .rd_wide(rd_wide),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_phys(rd_phys),
    .rd_err(rd_err), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_en(prot_en), .rp_q(rp_q)
);

// File: tb/tb_rf_wreg_file.sv
module tb_rf_wreg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rd_mode = 2'b00;
    logic        rd_wide = 1'b0;
    logic [7:0]  rd_addr = 8'h00;
    logic [15:0] rd_data;
    logic [7:0]  rd_phys;
    logic        rd_err;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = 2'b00;
    logic        wr_wide = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic        wr_err;
    logic        rp_load = 1'b0;
    logic [7:0]  rp_value = 8'h00;
    logic        prot_en = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rf_wreg_file dut (
        .clk(clk), .rst(rst), .rd_mode(rd_mode), .rd_wide(rd_wide),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_phys(rd_phys),
        .rd_err(rd_err), .wr_en(wr_en), .wr_mode(wr_mode),
        .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_err(wr_err), .rp_load(rp_load), .rp_value(rp_value),
        .prot_en(prot_en)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic w,
                      input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = m; wr_wide = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] m, input logic w, input logic [7:0] a);
        @(negedge clk);
        rd_mode = m; rd_wide = w; rd_addr = a;
        #1;
    endtask

    task automatic set_ptr(input logic [7:0] v);
        @(negedge clk);
        rp_load = 1'b1; rp_value = v;
        @(posedge clk);
        #1 rp_load = 1'b0;
    endtask

    task automatic t_reset_state;
        rd(2'b00, 1'b0, 8'hFD);
        check("R8", "pointer after reset", rd_data, 16'h0000);
    endtask

    task automatic t_direct_bytes;
        wr(2'b00, 1'b0, 8'h10, 16'h00A5);
        rd(2'b00, 1'b0, 8'h10);
        check("R1", "byte at 10H", rd_data, 16'h00A5);
        wr(2'b00, 1'b0, 8'h04, 16'h0011);
        wr(2'b00, 1'b0, 8'h7F, 16'h007E);
        rd(2'b00, 1'b0, 8'h04);
        check("R1", "first cell 04H", rd_data, 16'h0011);
        rd(2'b00, 1'b0, 8'h7F);
        check("R4", "byte read upper zero at 7FH", rd_data, 16'h007E);
    endtask

    task automatic t_working;
        set_ptr(8'h30);
        wr(2'b01, 1'b0, 8'h05, 16'h003C);
        rd(2'b00, 1'b0, 8'h35);
        check("R2", "working write lands at 35H", rd_data, 16'h003C);
        rd(2'b01, 1'b0, 8'hF5);
        check("R2", "resolved address ignores upper bits", {8'h00, rd_phys}, 16'h0035);
    endtask

    task automatic t_redirect;
        rd(2'b00, 1'b0, 8'hE5);
        check("R3", "direct E5H resolves to group", {8'h00, rd_phys}, 16'h0035);
        check("R3", "direct E5H data", rd_data, 16'h003C);
        wr(2'b10, 1'b0, 8'hE5, 16'h0077);
        rd(2'b10, 1'b0, 8'hE5);
        check("R3", "indirect E5H literal", rd_data, 16'h0077);
        rd(2'b11, 1'b0, 8'hE5);
        check("R3", "mode 11 literal", {8'h00, rd_phys}, 16'h00E5);
        set_ptr(8'hE0);
        rd(2'b01, 1'b0, 8'h05);
        check("R3", "working via group E", rd_data, 16'h0077);
    endtask

    task automatic t_pairs;
        wr(2'b00, 1'b1, 8'h20, 16'h1234);
        rd(2'b00, 1'b0, 8'h20);
        check("R4", "pair high byte at even", rd_data, 16'h0012);
        rd(2'b00, 1'b0, 8'h21);
        check("R4", "pair low byte at odd", rd_data, 16'h0034);
        rd(2'b00, 1'b1, 8'h20);
        check("R4", "pair read", rd_data, 16'h1234);
        set_ptr(8'h40);
        wr(2'b01, 1'b1, 8'h02, 16'hBEEF);
        rd(2'b00, 1'b0, 8'h42);
        check("R4", "working pair high", rd_data, 16'h00BE);
        wr(2'b10, 1'b1, 8'hEE, 16'hCAFE);
        rd(2'b10, 1'b1, 8'hEE);
        check("R4", "top pair EEH", rd_data, 16'hCAFE);
    endtask

    task automatic t_bad_pairs;
        wr(2'b00, 1'b0, 8'h31, 16'h0011);
        wr(2'b00, 1'b0, 8'h32, 16'h0022);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = 2'b00; wr_wide = 1'b1;
        wr_addr = 8'h31; wr_data = 16'hFFFF;
        #1 check("R5", "wr_err on odd base", {15'b0, wr_err}, 16'h0001);
        @(posedge clk);
        #1 wr_en = 1'b0;
        rd(2'b00, 1'b0, 8'h31);
        check("R5", "odd pair left 31H", rd_data, 16'h0011);
        rd(2'b00, 1'b0, 8'h32);
        check("R5", "odd pair left 32H", rd_data, 16'h0022);
        rd(2'b00, 1'b1, 8'h31);
        check("R5", "rd_err odd base", {15'b0, rd_err}, 16'h0001);
        check("R5", "odd base read data", rd_data, 16'h0000);
        rd(2'b00, 1'b1, 8'h02);
        check("R5", "rd_err pair below range", {15'b0, rd_err}, 16'h0001);
    endtask

    task automatic t_pointer;
        wr(2'b00, 1'b0, 8'hFD, 16'h0050);
        rd(2'b00, 1'b0, 8'hFD);
        check("R6", "pointer via write port", rd_data, 16'h0050);
        @(negedge clk);
        rp_load = 1'b1; rp_value = 8'h60;
        wr_en = 1'b1; wr_mode = 2'b00; wr_wide = 1'b0;
        wr_addr = 8'hFD; wr_data = 16'h0070;
        @(posedge clk);
        #1 begin rp_load = 1'b0; wr_en = 1'b0; end
        rd(2'b00, 1'b0, 8'hFD);
        check("R6", "load beats port write", rd_data, 16'h0060);
    endtask

    task automatic t_protect;
        wr(2'b00, 1'b0, 8'h90, 16'h005A);
        @(negedge clk) prot_en = 1'b1;
        rd(2'b00, 1'b0, 8'h90);
        check("R7", "protected read", rd_data, 16'h0000);
        rd(2'b10, 1'b1, 8'hEE);
        check("R7", "protected pair read", rd_data, 16'h0000);
        wr(2'b00, 1'b0, 8'h90, 16'h00C3);
        rd(2'b00, 1'b0, 8'h7F);
        check("R7", "7FH outside window", rd_data, 16'h007E);
        @(negedge clk) prot_en = 1'b0;
        rd(2'b00, 1'b0, 8'h90);
        check("R7", "protected write dropped", rd_data, 16'h005A);
    endtask

    task automatic t_void;
        wr(2'b00, 1'b0, 8'h02, 16'h0099);
        rd(2'b00, 1'b0, 8'h02);
        check("R9", "port area reads zero", rd_data, 16'h0000);
        wr(2'b00, 1'b0, 8'hF0, 16'h0099);
        rd(2'b00, 1'b0, 8'hF0);
        check("R9", "control area F0H reads zero", rd_data, 16'h0000);
        rd(2'b00, 1'b0, 8'hFD);
        check("R9", "pointer untouched by F0H write", rd_data, 16'h0060);
    endtask

    task automatic t_retain;
        wr(2'b00, 1'b0, 8'h60, 16'h0081);
        set_ptr(8'h70);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(2'b00, 1'b0, 8'h60);
        check("R8", "cell kept across reset", rd_data, 16'h0081);
        rd(2'b00, 1'b0, 8'hFD);
        check("R8", "pointer cleared", rd_data, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_direct_bytes();
        t_working();
        t_redirect();
        t_pairs();
        t_bad_pairs();
        t_pointer();
        t_protect();
        t_void();
        t_retain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule